// File: doc/BRIEF.md
# Key-Protected Flash Timing Tick Generator

This block produces the slow timing strobe that a flash memory controller uses to pace its program and erase steps. It counts system clocks and emits a one-cycle pulse every N cycles. N comes from an 8-bit divider register. Software picks N so that N system-clock periods land inside a 5.1 to 6.5 µs window. For clocks of about 616 kHz and faster, N is the ceiling of the clock frequency in MHz times 5.1. For the three slowest supported clock bands, N is 1, 2 or 3.

A mistaken write to the divider would put the flash timing out of range, so the divider register is write-protected. Before a divider write is accepted, software must send a two-write key to a separate key register: B6h, then 49h. Each unlock allows exactly one divider write. After that write the protection closes again. A status bit shows whether the protection is currently open.

The block is reached through a plain register port: address, write data, write strobe and a combinational read-data bus. The port has no handshake. Every strobed write completes in the cycle it is presented. The tick output is a bare pulse with no back-pressure, because the flash controller samples it every cycle.

Top module: `flash_tick_gen`

## Requirements
- R1: After reset the divider register (address 0) reads 01h, the status bit reads 0, and `tick` is high in every cycle.
- R2: With divider value N, `tick` is a one-cycle pulse that repeats every N system clocks. When N is 1, `tick` stays high.
- R3: While the status bit is 0, a write to address 0 is ignored and the divider reads back unchanged.
- R4: A write of B6h to address 1, followed directly by a write of 49h to address 1, sets the status bit (bit 0 of address 1) to 1.
- R5: The unlock sequence is cancelled and the status bit stays 0 if, in place of the expected second key write, there is a wrong key value, 49h sent first, or a write to address 0.
- R6: While the status bit is 1, one write to address 0 is accepted and the status bit returns to 0. A second write without a fresh unlock is ignored.
- R7: An accepted write of 00h stores 01h.
- R8: A new divider value applies only at the next tick boundary. The period in progress completes at its old length, and the following periods use the new length.
- R9: Reads need no unlock. Address 1 reads the status bit in bit 0 with zeros above it. Addresses 2 and 3 read 00h.
- R10: Writes to addresses 2 and 3 change neither the divider nor the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address (0 divider, 1 key/status) |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick | output | 1 | Flash timing pulse, one cycle every N clocks |

## Verification
The tick spacing is measured with divider values 1, 3, 10 and 255. A value of 1 separates a level that never drops from a pulse train. The other values expose off-by-one errors in the reload and any truncation of the count width. Key traffic is sent in the right order, in reverse order, with a wrong second byte, and with a divider write placed between the two key bytes. This shows whether the lock follows the exact two-step sequence or responds to any key activity. A divider change made partway through a period shows whether the new value is applied early or only at the next tick boundary.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;
  localparam int REG_DW = 8;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADR_DIV = 2'd0;
  localparam logic [REG_AW-1:0] ADR_KEY = 2'd1;
  localparam logic [REG_DW-1:0] KEY_FIRST  = 8'hB6;
  localparam logic [REG_DW-1:0] KEY_SECOND = 8'h49;

  typedef enum logic [1:0] {
    LK_SHUT  = 2'd0,
    LK_HALF  = 2'd1,
    LK_OPEN  = 2'd2
  } lock_st_e;
endpackage

// File: rtl/flash_key_lock.sv
module flash_key_lock
  import flash_tick_pkg::*;
#(
  parameter int DW = REG_DW,
  parameter logic [DW-1:0] K1 = KEY_FIRST,
  parameter logic [DW-1:0] K2 = KEY_SECOND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic          div_wr,
  input  logic [DW-1:0] wdata,
  output logic          is_open,
  output lock_st_e      state
);
  lock_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= LK_SHUT;
    end else if (key_wr) begin
      if (st_q == LK_HALF)
        st_q <= (wdata == K2) ? LK_OPEN : LK_SHUT;
      else
        st_q <= (wdata == K1) ? LK_HALF : LK_SHUT;
    end else if (div_wr) begin
      st_q <= LK_SHUT;
    end
  end

  assign is_open = (st_q == LK_OPEN);
  assign state   = st_q;
endmodule

// File: rtl/flash_div_counter.sv
module flash_div_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] period,
  output logic          pulse,
  output logic [DW-1:0] count
);
  logic [DW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (at_end)
      cnt_q <= period - DW'(1);
    else
      cnt_q <= cnt_q - DW'(1);
  end

  assign pulse = rst_n && at_end;
  assign count = cnt_q;
endmodule

// File: rtl/flash_tick_gen.sv
module flash_tick_gen
  import flash_tick_pkg::*;
#(
  parameter int DW = REG_DW,
  parameter int AW = REG_AW,
  parameter logic [DW-1:0] K1 = KEY_FIRST,
  parameter logic [DW-1:0] K2 = KEY_SECOND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tick
);
  localparam logic [DW-1:0] DIV_RST = DW'(1);

  logic          key_wr, div_wr, div_take, unlocked;
  logic [DW-1:0] div_q, cnt_w;
  lock_st_e      lk_state;

  assign key_wr   = reg_we && (reg_addr == AW'(ADR_KEY));
  assign div_wr   = reg_we && (reg_addr == AW'(ADR_DIV));
  assign div_take = div_wr && unlocked;

  flash_key_lock #(.DW(DW), .K1(K1), .K2(K2)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .div_wr(div_wr),
    .wdata(reg_wdata), .is_open(unlocked), .state(lk_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_q <= DIV_RST;
    else if (div_take)
      div_q <= (reg_wdata == '0) ? DIV_RST : reg_wdata;
  end

  flash_div_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .period(div_q), .pulse(tick), .count(cnt_w)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADR_DIV))
      reg_rdata = div_q;
    else if (reg_addr == AW'(ADR_KEY))
      reg_rdata = {{(DW-1){1'b0}}, unlocked};
  end
endmodule

// File: rtl/flash_tick_chk.sv
module flash_tick_chk
  import flash_tick_pkg::*;
#(
  parameter int DW = REG_DW,
  parameter int AW = REG_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic          tick,
  input logic          unlocked,
  input lock_st_e      lk_state,
  input logic [DW-1:0] div_q,
  input logic [DW-1:0] cnt_w
);
  always @(posedge clk)
    if (rst_n) a_r7_never_zero: assert (div_q != '0);

  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(ADR_DIV) && !unlocked) |=> $stable(div_q));

  a_r6_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(ADR_DIV) && unlocked) |=> !unlocked);

  a_r4_open: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(ADR_KEY) && lk_state == LK_HALF && reg_wdata == KEY_SECOND)
    |=> unlocked);

  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(ADR_KEY) && reg_wdata != KEY_FIRST && reg_wdata != KEY_SECOND)
    |=> !unlocked);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q > DW'(1)) |=> !tick);

  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && $past(rst_n)) |=> (cnt_w == $past(cnt_w) - DW'(1)));

  a_r10_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != AW'(ADR_DIV) && reg_addr != AW'(ADR_KEY))
    |=> ($stable(div_q) && $stable(lk_state)));
endmodule

bind flash_tick_gen flash_tick_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .tick(tick), .unlocked(unlocked),
  .lk_state(lk_state), .div_q(div_q), .cnt_w(cnt_w)
);

// File: tb/flash_tick_gen_tb.sv
module flash_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic unlock();
    wr(2'd1, 8'hB6); wr(2'd1, 8'h49);
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  task automatic period_of(output int p);
    int t0;
    wait_tick(); wait_tick(); t0 = cyc;
    wait_tick(); p = cyc - t0;
  endtask

  task automatic t_reset();
    int v;
    rd(2'd0, v); check("R1 div reset", v, 1);
    rd(2'd1, v); check("R1 status reset", v, 0);
    for (int i = 0; i < 3; i++) begin
      check("R1 tick every cycle", int'(tick), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_locked_write();
    int v;
    wr(2'd0, 8'd7); rd(2'd0, v); check("R3 locked write ignored", v, 1);
  endtask

  task automatic t_unlock_and_once();
    int v;
    unlock(); rd(2'd1, v); check("R4 status open", v, 1);
    wr(2'd0, 8'd3); rd(2'd0, v); check("R6 accepted write", v, 3);
    rd(2'd1, v); check("R6 status closed", v, 0);
    wr(2'd0, 8'd9); rd(2'd0, v); check("R6 second write ignored", v, 3);
  endtask

  task automatic t_bad_sequences();
    int v;
    wr(2'd1, 8'hB6); wr(2'd1, 8'h48); rd(2'd1, v); check("R5 wrong value", v, 0);
    wr(2'd1, 8'h49); wr(2'd1, 8'hB6); rd(2'd1, v); check("R5 reversed order", v, 0);
    wr(2'd1, 8'hB6); wr(2'd0, 8'd5); wr(2'd1, 8'h49); rd(2'd1, v);
    check("R5 divider write between keys", v, 0);
    rd(2'd0, v); check("R5 divider unchanged", v, 3);
  endtask

  task automatic t_other_addr();
    int v;
    wr(2'd1, 8'hB6); wr(2'd2, 8'h49); wr(2'd3, 8'h11); wr(2'd1, 8'h49);
    rd(2'd1, v); check("R10 unmapped writes keep lock sequence", v, 1);
    rd(2'd2, v); check("R9 addr2 reads zero", v, 0);
    rd(2'd3, v); check("R9 addr3 reads zero", v, 0);
    wr(2'd0, 8'd3);
    rd(2'd0, v); check("R10 divider after unmapped writes", v, 3);
  endtask

  task automatic set_div(logic [7:0] d);
    unlock(); wr(2'd0, d);
  endtask

  task automatic t_periods();
    int p, v;
    period_of(p); check("R2 period 3", p, 3);
    set_div(8'd10); period_of(p); check("R2 period 10", p, 10);
    set_div(8'd255); period_of(p); check("R2 period 255", p, 255);
    set_div(8'd0); rd(2'd0, v); check("R7 zero stored as one", v, 1);
    period_of(p); check("R2 period 1", p, 1);
    check("R2 tick level with N=1", int'(tick), 1);
  endtask

  task automatic t_midperiod();
    int p, t0;
    set_div(8'd10);
    wait_tick(); wait_tick(); t0 = cyc;
    set_div(8'd4);
    wait_tick(); p = cyc - t0; check("R8 old period completes", p, 10);
    t0 = cyc; wait_tick(); p = cyc - t0; check("R8 new period used", p, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_write();
    t_unlock_and_once();
    t_bad_sequences();
    t_other_addr();
    t_periods();
    t_midperiod();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule